// File: doc/BRIEF.md
# Single-Channel Block Copy Engine with Bus Tenure Control

This block copies a run of words from one place in the address space to another without the processor moving any data itself. Software writes a source word address, a destination word address and a word count into the block's registers, picks a burst size, and sets a run bit. The engine then asks for ownership of the shared bus. Once ownership is granted, it reads each word from the source and writes it to the destination.

The engine holds the bus only for one short burst at a time. After each burst it lets go of the bus and asks again, so other masters get regular turns. Software can pause a job by clearing the run bit. The job stops at the end of the current burst and keeps its position, and setting the bit again continues from where it stopped. When the last word has been written, a sticky done flag and the interrupt line go high. They stay high until software clears them by writing 1.

The master side is a single-beat word interface with a valid/ready handshake. All addresses on it count words, so one word is one address step.

Top module: `dma_mover`

## Requirements
- R1: Register map on `csr_addr`: 0 source word address, 1 destination word address, 2 word count, 3 control/status. In the control/status word, bit 0 is run, bit 1 is busy (read only), bit 2 is done (reads the flag; writing 1 clears it) and bits [8:4] are the burst size. After reset every register reads 0, except control/status, which reads 0x40 (burst size 4).
- R2: The engine raises `bus_req` before any master access and holds it until `bus_gnt` is seen. `m_valid` never rises unless `bus_gnt` was high in the cycle before.
- R3: Each bus tenure moves min(B, remaining words) words. B is the burst field clamped to the range 4..16, so a value below 4 acts as 4 and a value above 16 acts as 16.
- R4: After every tenure, `bus_req` stays low for at least one full cycle before it rises again.
- R5: Each word is read from the current source address and then written, with the data just read, to the current destination address. Both addresses then step up by one. No address outside the programmed range is written.
- R6: When the last word is written, done and `irq` go high, busy and run go low, and done and `irq` stay high until a control write with bit 2 set.
- R7: Clearing run during a job stops the engine at the end of the current burst, with busy still high. Setting run again finishes the remaining words without any reprogramming.
- R8: Starting with a word count of 0 sets done and `irq` at once and never raises `bus_req`.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_write`, `m_addr` and `m_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| m_valid | output | 1 | Master access valid |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Master word address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data, valid with m_ready on a read |
| m_ready | input | 1 | Access accepted in this cycle |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The assertions rely on two things about the inputs. The arbiter only grants while a request is pending, and the slave raises `m_ready` only while `m_valid` is high. The bench's responder keeps to both. It drives the grant two falling edges after it sees a request and withdraws it as soon as the request drops. It answers every access with one wait cycle and then one ready cycle. Register writes are issued only at falling edges and last one cycle, so software and engine updates to run and done never land on an undefined edge.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_GAP  = 3'd4
    } eng_state_e;

    localparam logic [1:0] RA_SRC  = 2'd0;
    localparam logic [1:0] RA_DST  = 2'd1;
    localparam logic [1:0] RA_LEN  = 2'd2;
    localparam logic [1:0] RA_CTRL = 2'd3;

    function automatic int unsigned clamp_burst(input int unsigned v,
                                                input int unsigned lo,
                                                input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int LW        = 16,
    parameter int BW        = 5,
    parameter int MIN_BURST = 4,
    parameter int MAX_BURST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    input  logic          busy,
    input  logic          go_clr,
    input  logic          done_set,
    output logic          go,
    output logic [AW-1:0] src_cfg,
    output logic [AW-1:0] dst_cfg,
    output logic [LW-1:0] len_cfg,
    output logic [BW-1:0] burst_eff,
    output logic          irq
);

    localparam logic [BW-1:0] BURST_RST = BW'(MIN_BURST);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic [BW-1:0] burst;
        logic          go;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (go_clr) r_d.go = 1'b0;
        if (csr_we) begin
            case (csr_addr)
                RA_SRC:  r_d.src = csr_wdata[AW-1:0];
                RA_DST:  r_d.dst = csr_wdata[AW-1:0];
                RA_LEN:  r_d.len = csr_wdata[LW-1:0];
                default: begin
                    r_d.go    = csr_wdata[0];
                    r_d.burst = csr_wdata[4 +: BW];
                    if (csr_wdata[2]) r_d.done = 1'b0;
                end
            endcase
        end
        if (done_set) r_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.burst <= BURST_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            RA_SRC:  csr_rdata[AW-1:0] = r_q.src;
            RA_DST:  csr_rdata[AW-1:0] = r_q.dst;
            RA_LEN:  csr_rdata[LW-1:0] = r_q.len;
            default: begin
                csr_rdata[0]       = r_q.go;
                csr_rdata[1]       = busy;
                csr_rdata[2]       = r_q.done;
                csr_rdata[4 +: BW] = r_q.burst;
            end
        endcase
    end

    assign go        = r_q.go;
    assign src_cfg   = r_q.src;
    assign dst_cfg   = r_q.dst;
    assign len_cfg   = r_q.len;
    assign burst_eff = BW'(clamp_burst(int'(r_q.burst), MIN_BURST, MAX_BURST));
    assign irq       = r_q.done;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(csr_we && csr_addr == RA_CTRL && csr_wdata[2])) |=> irq); // R6

    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_eff >= BW'(MIN_BURST)) && (burst_eff <= BW'(MAX_BURST))); // R3

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int LW        = 16,
    parameter int BW        = 5,
    parameter int MAX_BURST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] src_cfg,
    input  logic [AW-1:0] dst_cfg,
    input  logic [LW-1:0] len_cfg,
    input  logic [BW-1:0] burst_eff,
    output logic          go_clr,
    output logic          done_set,
    output logic          busy,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          m_valid,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ready
);

    localparam logic [LW-1:0] BURST_PAD = '0;

    typedef struct packed {
        eng_state_e    st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] rem;
        logic [BW-1:0] beats;
        logic [DW-1:0] hold;
        logic          live;
    } eng_t;

    eng_t e_d, e_q;
    logic [LW-1:0] burst_wide;

    assign burst_wide = BURST_PAD | LW'(burst_eff);

    always_comb begin
        e_d      = e_q;
        go_clr   = 1'b0;
        done_set = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                if (go) begin
                    if (!e_q.live) begin
                        if (len_cfg == '0) begin
                            done_set = 1'b1;
                            go_clr   = 1'b1;
                        end else begin
                            e_d.src  = src_cfg;
                            e_d.dst  = dst_cfg;
                            e_d.rem  = len_cfg;
                            e_d.live = 1'b1;
                            e_d.st   = ST_REQ;
                        end
                    end else begin
                        e_d.st = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    e_d.beats = (e_q.rem < burst_wide) ? e_q.rem[BW-1:0] : burst_eff;
                    e_d.st    = ST_RD;
                end
            end
            ST_RD: begin
                if (m_ready) begin
                    e_d.hold = m_rdata;
                    e_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (m_ready) begin
                    e_d.src   = e_q.src + 1'b1;
                    e_d.dst   = e_q.dst + 1'b1;
                    e_d.rem   = e_q.rem - 1'b1;
                    e_d.beats = e_q.beats - 1'b1;
                    if (e_q.rem == LW'(1)) begin
                        e_d.live = 1'b0;
                        done_set = 1'b1;
                        go_clr   = 1'b1;
                        e_d.st   = ST_GAP;
                    end else if (e_q.beats == BW'(1)) begin
                        e_d.st = ST_GAP;
                    end else begin
                        e_d.st = ST_RD;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy    = e_q.live;
    assign bus_req = (e_q.st == ST_REQ) || (e_q.st == ST_RD) || (e_q.st == ST_WR);
    assign m_valid = (e_q.st == ST_RD) || (e_q.st == ST_WR);
    assign m_write = (e_q.st == ST_WR);
    assign m_addr  = (e_q.st == ST_WR) ? e_q.dst : e_q.src;
    assign m_wdata = e_q.hold;

    AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(bus_gnt)); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !m_valid && !bus_gnt) |=> bus_req); // R2

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |=> !bus_req); // R4

    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (e_q.beats != '0) && (e_q.beats <= BW'(MAX_BURST))); // R3

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_write) && $stable(m_addr)
                                   && $stable(m_wdata))); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_write && m_ready && e_q.rem != LW'(1))
        |=> (e_q.src == $past(e_q.src) + 1'b1) && (e_q.dst == $past(e_q.dst) + 1'b1)); // R5

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int LW        = 16,
    parameter int MIN_BURST = 4,
    parameter int MAX_BURST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          m_valid,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ready,
    output logic          irq
);

    localparam int BW = $clog2(MAX_BURST + 1);

    logic          go, go_clr, done_set, busy;
    logic [AW-1:0] src_cfg, dst_cfg;
    logic [LW-1:0] len_cfg;
    logic [BW-1:0] burst_eff;

    dma_regs #(
        .DW(DW), .AW(AW), .LW(LW), .BW(BW),
        .MIN_BURST(MIN_BURST), .MAX_BURST(MAX_BURST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .busy(busy), .go_clr(go_clr), .done_set(done_set),
        .go(go), .src_cfg(src_cfg), .dst_cfg(dst_cfg), .len_cfg(len_cfg),
        .burst_eff(burst_eff), .irq(irq)
    );

    dma_engine #(
        .DW(DW), .AW(AW), .LW(LW), .BW(BW), .MAX_BURST(MAX_BURST)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .go(go), .src_cfg(src_cfg), .dst_cfg(dst_cfg), .len_cfg(len_cfg),
        .burst_eff(burst_eff),
        .go_clr(go_clr), .done_set(done_set), .busy(busy),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready)
    );

    AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && len_cfg == '0 && !bus_req) |=> !bus_req); // R8

endmodule

// File: tb/dma_mover_test.sv
module dma_mover_test;

    localparam int PERIOD = 10;
    localparam int NVEC   = 5;

    // {src, dst, len, burst field, expected tenures, expected max beats}
    localparam logic [71:0] VEC [0:NVEC-1] = '{
        {16'h0010, 16'h0080, 16'd5,  8'd4,  8'd2, 8'd4},
        {16'h0020, 16'h0090, 16'd16, 8'd16, 8'd1, 8'd16},
        {16'h0030, 16'h00A0, 16'd20, 8'd31, 8'd2, 8'd16},
        {16'h0040, 16'h00C0, 16'd9,  8'd1,  8'd3, 8'd4},
        {16'h0050, 16'h00E0, 16'd3,  8'd8,  8'd1, 8'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        bus_req, bus_gnt = 1'b0;
    logic        m_valid, m_write;
    logic [31:0] m_addr, m_wdata;
    logic [31:0] m_rdata = '0;
    logic        m_ready = 1'b0;
    logic        irq;

    logic [31:0] mem [0:255];
    int checks = 0, fails = 0;
    int tenures = 0, cur_beats = 0, max_beats = 0, total_wr = 0;
    int gnt_wait = 0;
    logic prev_req = 1'b0;
    bit   done_flag = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dma_mover uut (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
        .irq(irq)
    );

    function automatic logic [31:0] pat(input int a);
        return 32'h5A00_0000 + a * 32'h0001_0003;
    endfunction

    // Arbiter, slave memory and tenure monitor, all acting on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req && !prev_req) begin
                tenures++;
                cur_beats = 0;
            end
            prev_req = bus_req;
            if (bus_req) begin
                gnt_wait++;
                bus_gnt = (gnt_wait >= 2);
            end else begin
                gnt_wait = 0;
                bus_gnt = 1'b0;
            end
            if (m_ready) begin
                m_ready = 1'b0;
            end else if (m_valid) begin
                m_ready = 1'b1;
                if (m_write) begin
                    mem[m_addr[7:0]] = m_wdata;
                    cur_beats++;
                    total_wr++;
                    if (cur_beats > max_beats) max_beats = cur_beats;
                end else begin
                    m_rdata = mem[m_addr[7:0]];
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1'b1; break; end
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        bit ok;
        int bad;
        for (int a = 0; a < 256; a++) mem[a] = pat(a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        csr_read(2'd0, rd); check("R1 src reset", rd, 32'h0);
        csr_read(2'd1, rd); check("R1 dst reset", rd, 32'h0);
        csr_read(2'd2, rd); check("R1 len reset", rd, 32'h0);
        csr_read(2'd3, rd); check("R1 ctrl reset", rd, 32'h40);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        check("R1 req reset", {31'b0, bus_req}, 32'h0);

        // Table-driven copies: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            int src  = int'(VEC[v][71:56]);
            int dst  = int'(VEC[v][55:40]);
            int len  = int'(VEC[v][39:24]);
            logic [7:0] bf = VEC[v][23:16];
            int eten = int'(VEC[v][15:8]);
            int emax = int'(VEC[v][7:0]);
            csr_write(2'd0, src);
            csr_write(2'd1, dst);
            csr_write(2'd2, len);
            csr_read(2'd0, rd); check("R1 src readback", rd, src);
            tenures = 0; max_beats = 0; total_wr = 0;
            csr_write(2'd3, {23'b0, bf[4:0], 4'b0001});
            wait_irq(ok);
            check("R6 irq raised", {31'b0, ok}, 32'h1);
            repeat (3) @(negedge clk);
            bad = 0;
            for (int i = 0; i < len; i++)
                if (mem[dst + i] !== pat(src + i)) bad++;
            check("R5 copied words wrong", bad, 0);
            check("R5 word past end untouched", mem[dst + len], pat(dst + len));
            check("R3 tenure count", tenures, eten);
            check("R3 largest burst", max_beats, emax);
            check("R5 total writes", total_wr, len);
            csr_read(2'd3, rd);
            check("R6 status run/busy/done", rd[2:0], 3'b100);
            check("R6 irq held", {31'b0, irq}, 32'h1);
            csr_write(2'd3, {23'b0, bf[4:0], 4'b0100});
            csr_read(2'd3, rd);
            check("R6 done cleared", rd[2:0], 3'b000);
            check("R6 irq cleared", {31'b0, irq}, 32'h0);
        end

        // R7 stall and resume: 12 words, burst 4, run cleared during the first burst
        csr_write(2'd0, 32'h60);
        csr_write(2'd1, 32'hF0);
        csr_write(2'd2, 32'd12);
        tenures = 0; max_beats = 0; total_wr = 0;
        csr_write(2'd3, 32'h41);
        for (int i = 0; i < 500 && total_wr == 0; i++) @(negedge clk);
        csr_write(2'd3, 32'h40);
        repeat (60) @(negedge clk);
        check("R7 writes at stall", total_wr, 4);
        check("R7 bus idle at stall", {31'b0, bus_req}, 32'h0);
        csr_read(2'd3, rd);
        check("R7 busy kept, not done", rd[2:0], 3'b010);
        check("R7 word 4 not yet written", mem[32'hF4], pat(32'hF4));
        csr_write(2'd3, 32'h41);
        wait_irq(ok);
        check("R7 resumed to completion", {31'b0, ok}, 32'h1);
        repeat (3) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 12; i++) if (mem[32'hF0 + i] !== pat(32'h60 + i)) bad++;
        check("R7 all words after resume", bad, 0);
        check("R7 total writes", total_wr, 12);
        csr_write(2'd3, 32'h44);

        // R8 zero length
        csr_write(2'd2, 32'd0);
        tenures = 0;
        csr_write(2'd3, 32'h41);
        repeat (5) @(negedge clk);
        check("R8 no bus request", tenures, 0);
        check("R8 irq set", {31'b0, irq}, 32'h1);
        csr_read(2'd3, rd);
        check("R8 done, run cleared", rd[2:0], 3'b100);
        csr_write(2'd3, 32'h44);
        check("R8 irq cleared", {31'b0, irq}, 32'h0);

        finish_run();
    end

endmodule